// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the fifteen 32-bit general registers of a processor core that runs in several privilege modes. Registers 0 to 14 sit in a live array that both combinational read ports see directly. Register 15, the program counter, is kept elsewhere. Behind the live array sit private copies that belong to particular modes. The stack register (13) and the link register (14) each have six slots, one per mode group. Registers 8 to 12 have one extra set that is private to the fast-interrupt mode, plus a shadow set for every other mode.

The core drives the mode currently in force on `cur_mode`. To switch modes, it pulses `chg_en` for one cycle with the target mode on `chg_mode`. On that clock edge the block saves the live copies into the outgoing mode's storage and loads the incoming mode's copies into the live array. Later reads and writes therefore reach the right physical registers, and the core never has to handle bank numbers. When an exception causes the switch, the core can also assert `chg_link_en` so that the return address on `chg_link_val` lands in the new mode's link register.

Top module: `rbank_regfile`

## Requirements
- R1: A synchronous active-high reset clears every live register, every stack/link slot and both sets of registers 8–12 to zero.
- R2: Each of the two read ports returns the live value of the register named by its 4-bit index. Index 15 reads as zero. A write to index 15 changes nothing.
- R3: A write with `wr_en` high takes effect at the next rising edge. A read of that register in the same cycle still returns the old value.
- R4: Mode codes are 5 bits: 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined, 11111 system. The stack/link slot of each mode is user and system 0, fast interrupt 1, interrupt 2, supervisor 3, abort 4, undefined 5.
- R5: On a mode change, live registers 13 and 14 are stored into the slot of `cur_mode` and reloaded from the slot of `chg_mode`. When both modes share one slot, including a change to the same mode, registers 13 and 14 keep their values.
- R6: With `chg_link_en` high during a change, register 14 of the new mode takes `chg_link_val` and holds it from the next cycle.
- R7: Changing into fast-interrupt mode from any other mode stores live registers 8–12 into the shadow set and loads the fast-interrupt set.
- R8: Changing out of fast-interrupt mode into any other mode stores live registers 8–12 into the fast-interrupt set and restores the shadow set.
- R9: A change in which neither mode is fast interrupt, or both are, leaves registers 8–12 untouched. No mode change ever alters registers 0–7.
- R10: A write in the same cycle as a mode change goes to the outgoing mode's copy of the register, before the copies are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_mode | input | 5 | Mode currently in force |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| chg_en | input | 1 | One-cycle mode change strobe |
| chg_mode | input | 5 | Mode being entered |
| chg_link_en | input | 1 | Load the return address into the new link register |
| chg_link_val | input | 32 | Return address |

## Verification
The assertions assume that `cur_mode` always equals the mode set by the most recent change and that only the seven listed mode codes occur. With other codes, the slot and swap rules the properties encode have no meaning. The bench keeps its own record of the current mode, drives `cur_mode` from that record, and draws every change target from the seven legal codes. This covers same-slot pairs such as user and system, and repeated entry into the fast-interrupt mode.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

    localparam int MODE_W   = 5;
    localparam int LIVE_CNT = 15;
    localparam int IDX_W    = 4;
    localparam int SLOT_CNT = 6;
    localparam int SLOT_W   = $clog2(SLOT_CNT);
    localparam int HI_BASE  = 8;
    localparam int HI_CNT   = 5;
    localparam int SP_IDX   = 13;
    localparam int LR_IDX   = 14;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [MODE_W-1:0] {
        MD_USR = 5'b10000,
        MD_FIQ = 5'b10001,
        MD_IRQ = 5'b10010,
        MD_SVC = 5'b10011,
        MD_ABT = 5'b10111,
        MD_UND = 5'b11011,
        MD_SYS = 5'b11111
    } mode_e;

    typedef struct packed {
        logic  active;
        logic  enter_fiq;
        logic  leave_fiq;
        logic  same_slot;
        slot_t old_slot;
        slot_t new_slot;
    } swap_ctl_t;

    // Slot used by registers 13/14; unknown codes fall into the shared user slot
    function automatic slot_t slot_of(mode_t m);
        case (m)
            MD_USR, MD_SYS: return slot_t'(0);
            MD_FIQ:         return slot_t'(1);
            MD_IRQ:         return slot_t'(2);
            MD_SVC:         return slot_t'(3);
            MD_ABT:         return slot_t'(4);
            MD_UND:         return slot_t'(5);
            default:        return slot_t'(0);
        endcase
    endfunction

    function automatic logic is_fiq(mode_t m);
        return m == MD_FIQ;
    endfunction

    function automatic swap_ctl_t plan_swap(logic en, mode_t from_m, mode_t to_m);
        swap_ctl_t c;
        c.active    = en;
        c.old_slot  = slot_of(from_m);
        c.new_slot  = slot_of(to_m);
        c.same_slot = (c.old_slot == c.new_slot);
        c.enter_fiq = en && is_fiq(to_m) && !is_fiq(from_m);
        c.leave_fiq = en && is_fiq(from_m) && !is_fiq(to_m);
        return c;
    endfunction

endpackage

// File: rtl/rbank_wr_merge.sv
module rbank_wr_merge #(
    parameter int DATA_W = 32,
    parameter int CNT    = 15,
    parameter int IDX_W  = 4
) (
    input  logic [CNT-1:0][DATA_W-1:0] live_i,
    input  logic                       wr_en_i,
    input  logic [IDX_W-1:0]           wr_idx_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    output logic [CNT-1:0][DATA_W-1:0] merged_o
);

    // Live view with the pending write folded in; indices past CNT hit nothing
    for (genvar i = 0; i < CNT; i++) begin : g_reg
        assign merged_o[i] = (wr_en_i && (wr_idx_i == IDX_W'(i))) ? wr_data_i : live_i[i];
    end

endmodule

// File: rtl/rbank_slot_bank.sv
module rbank_slot_bank #(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 6,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              save_en_i,
    input  logic [IDX_W-1:0]  save_idx_i,
    input  logic [DATA_W-1:0] save_val_i,
    input  logic              ovr_en_i,
    input  logic [IDX_W-1:0]  ovr_idx_i,
    input  logic [DATA_W-1:0] ovr_val_i,
    input  logic [IDX_W-1:0]  load_idx_i,
    output logic [DATA_W-1:0] load_val_o
);

    logic [SLOTS-1:0][DATA_W-1:0] slot_q;

    // Override is written after the save so it wins on a shared slot
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            if (save_en_i) slot_q[save_idx_i] <= save_val_i;
            if (ovr_en_i)  slot_q[ovr_idx_i]  <= ovr_val_i;
        end
    end

    assign load_val_o = (load_idx_i < IDX_W'(SLOTS)) ? slot_q[load_idx_i] : '0;

endmodule

// File: rtl/rbank_hi_shadow.sv
module rbank_hi_shadow #(
    parameter int DATA_W = 32,
    parameter int CNT    = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enter_i,
    input  logic                       leave_i,
    input  logic [CNT-1:0][DATA_W-1:0] live_i,
    output logic [CNT-1:0][DATA_W-1:0] usr_o,
    output logic [CNT-1:0][DATA_W-1:0] fiq_o
);

    logic [CNT-1:0][DATA_W-1:0] usr_q;
    logic [CNT-1:0][DATA_W-1:0] fiq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            usr_q <= '0;
            fiq_q <= '0;
        end else begin
            if (enter_i) usr_q <= live_i;
            if (leave_i) fiq_q <= live_i;
        end
    end

    assign usr_o = usr_q;
    assign fiq_o = fiq_q;

endmodule

// File: rtl/rbank_rd_port.sv
module rbank_rd_port #(
    parameter int DATA_W = 32,
    parameter int CNT    = 15,
    parameter int IDX_W  = 4
) (
    input  logic [CNT-1:0][DATA_W-1:0] live_i,
    input  logic [IDX_W-1:0]           idx_i,
    output logic [DATA_W-1:0]          data_o
);

    assign data_o = (idx_i < IDX_W'(CNT)) ? live_i[idx_i] : '0;

endmodule

// File: rtl/rbank_regfile.sv
module rbank_regfile
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              chg_en,
    input  logic [MODE_W-1:0] chg_mode,
    input  logic              chg_link_en,
    input  logic [DATA_W-1:0] chg_link_val
);

    logic [LIVE_CNT-1:0][DATA_W-1:0] live_q;
    logic [LIVE_CNT-1:0][DATA_W-1:0] merged;
    logic [LIVE_CNT-1:0][DATA_W-1:0] live_d;
    logic [1:0][DATA_W-1:0]          sl_load;
    logic [HI_CNT-1:0][DATA_W-1:0]   usr_hi;
    logic [HI_CNT-1:0][DATA_W-1:0]   fiq_hi;
    swap_ctl_t                       ctl;

    assign ctl = plan_swap(chg_en, cur_mode, chg_mode);

    rbank_wr_merge #(.DATA_W(DATA_W), .CNT(LIVE_CNT), .IDX_W(IDX_W)) u_merge (
        .live_i    (live_q),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .merged_o  (merged)
    );

    // Slot storage for the stack (g=0) and link (g=1) registers
    for (genvar g = 0; g < 2; g++) begin : g_sl
        localparam int REG_NUM = SP_IDX + g;
        localparam bit IS_LINK = (g == 1);
        rbank_slot_bank #(.DATA_W(DATA_W), .SLOTS(SLOT_CNT)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .save_en_i  (ctl.active),
            .save_idx_i (ctl.old_slot),
            .save_val_i (merged[REG_NUM]),
            .ovr_en_i   (ctl.active && chg_link_en && IS_LINK),
            .ovr_idx_i  (ctl.new_slot),
            .ovr_val_i  (chg_link_val),
            .load_idx_i (ctl.new_slot),
            .load_val_o (sl_load[g])
        );
    end

    rbank_hi_shadow #(.DATA_W(DATA_W), .CNT(HI_CNT)) u_hi (
        .clk     (clk),
        .rst     (rst),
        .enter_i (ctl.enter_fiq),
        .leave_i (ctl.leave_fiq),
        .live_i  (merged[HI_BASE +: HI_CNT]),
        .usr_o   (usr_hi),
        .fiq_o   (fiq_hi)
    );

    always_comb begin
        live_d = merged;
        if (ctl.active) begin
            live_d[SP_IDX] = ctl.same_slot ? merged[SP_IDX] : sl_load[0];
            if (chg_link_en) begin
                live_d[LR_IDX] = chg_link_val;
            end else begin
                live_d[LR_IDX] = ctl.same_slot ? merged[LR_IDX] : sl_load[1];
            end
            if (ctl.enter_fiq) begin
                live_d[HI_BASE +: HI_CNT] = fiq_hi;
            end else if (ctl.leave_fiq) begin
                live_d[HI_BASE +: HI_CNT] = usr_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) live_q <= '0;
        else     live_q <= live_d;
    end

    rbank_rd_port #(.DATA_W(DATA_W), .CNT(LIVE_CNT), .IDX_W(IDX_W)) u_rd_a (
        .live_i (live_q),
        .idx_i  (rd_a_idx),
        .data_o (rd_a_data)
    );

    rbank_rd_port #(.DATA_W(DATA_W), .CNT(LIVE_CNT), .IDX_W(IDX_W)) u_rd_b (
        .live_i (live_q),
        .idx_i  (rd_b_idx),
        .data_o (rd_b_data)
    );

endmodule

// File: rtl/rbank_regfile_chk.sv
module rbank_regfile_chk
    import rbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                            clk,
    input logic                            rst,
    input logic [MODE_W-1:0]               cur_mode,
    input logic                            wr_en,
    input logic [IDX_W-1:0]                wr_idx,
    input logic [DATA_W-1:0]               wr_data,
    input logic                            chg_en,
    input logic [MODE_W-1:0]               chg_mode,
    input logic                            chg_link_en,
    input logic [DATA_W-1:0]               chg_link_val,
    input logic [LIVE_CNT-1:0][DATA_W-1:0] live_q,
    input logic [HI_CNT-1:0][DATA_W-1:0]   usr_hi,
    input logic [HI_CNT-1:0][DATA_W-1:0]   fiq_hi
);

    logic              plain_wr;
    logic [IDX_W-1:0]  wr_idx_q;
    logic [DATA_W-1:0] wr_data_q;

    assign plain_wr = wr_en && !chg_en && (wr_idx < IDX_W'(LIVE_CNT));

    always_ff @(posedge clk) begin
        wr_idx_q  <= wr_idx;
        wr_data_q <= wr_data;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (live_q == '0 && usr_hi == '0 && fiq_hi == '0));

    // R2
    pc_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_W'(15) && !chg_en) |=> $stable(live_q));

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        plain_wr |=> live_q[wr_idx_q] == wr_data_q);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !chg_en) |=> $stable(live_q));

    // R5
    shared_slot_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (chg_en && !wr_en && !chg_link_en && slot_of(cur_mode) == slot_of(chg_mode))
        |=> $stable(live_q[LR_IDX:SP_IDX]));

    // R6
    link_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (chg_en && chg_link_en) |=> live_q[LR_IDX] == $past(chg_link_val));

    // R7
    enter_fast_save_chk: assert property (@(posedge clk) disable iff (rst)
        (chg_en && !wr_en && is_fiq(chg_mode) && !is_fiq(cur_mode))
        |=> usr_hi == $past(live_q[HI_BASE+HI_CNT-1:HI_BASE]));

    // R8
    leave_fast_save_chk: assert property (@(posedge clk) disable iff (rst)
        (chg_en && !wr_en && is_fiq(cur_mode) && !is_fiq(chg_mode))
        |=> fiq_hi == $past(live_q[HI_BASE+HI_CNT-1:HI_BASE]));

    // R9
    low_hi_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        (chg_en && !wr_en && (is_fiq(cur_mode) == is_fiq(chg_mode)))
        |=> $stable(live_q[HI_BASE+HI_CNT-1:0]));

endmodule

bind rbank_regfile rbank_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cur_mode     (cur_mode),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .chg_en       (chg_en),
    .chg_mode     (chg_mode),
    .chg_link_en  (chg_link_en),
    .chg_link_val (chg_link_val),
    .live_q       (live_q),
    .usr_hi       (usr_hi),
    .fiq_hi       (fiq_hi)
);

// File: tb/rbank_regfile_test.sv
module rbank_regfile_test;

    localparam int DW = 32;
    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_SYS = 5'b11111;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    cur_mode = M_SVC;
    logic [3:0]    rd_a_idx = '0;
    logic [DW-1:0] rd_a_data;
    logic [3:0]    rd_b_idx = '0;
    logic [DW-1:0] rd_b_data;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          chg_en = 1'b0;
    logic [4:0]    chg_mode = M_SVC;
    logic          chg_link_en = 1'b0;
    logic [DW-1:0] chg_link_val = '0;

    always #2 clk = ~clk;

    rbank_regfile #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .cur_mode(cur_mode),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .chg_en(chg_en), .chg_mode(chg_mode),
        .chg_link_en(chg_link_en), .chg_link_val(chg_link_val)
    );

    int vec_cnt = 0;
    int bad_cnt = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_live [15];
    logic [DW-1:0] m_b13  [6];
    logic [DW-1:0] m_b14  [6];
    logic [DW-1:0] m_usr  [5];
    logic [DW-1:0] m_fiq  [5];
    logic [4:0]    m_mode = M_SVC;
    logic [4:0]    legal_modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                       5'b10111, 5'b11011, 5'b11111};

    // Slot numbering from R4
    function automatic int tb_slot(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [DW-1:0] tb_read(logic [3:0] i);
        if (i == 4'd15) return '0;
        return m_live[i];
    endfunction

    task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        vec_cnt++;
        if (got !== exp) begin
            bad_cnt++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 15; i++) m_live[i] = '0;
        for (int i = 0; i < 6; i++) begin m_b13[i] = '0; m_b14[i] = '0; end
        for (int i = 0; i < 5; i++) begin m_usr[i] = '0; m_fiq[i] = '0; end
    endtask

    task automatic step(input logic we, input logic [3:0] wi, input logic [DW-1:0] wd,
                        input logic ce, input logic [4:0] cm, input logic le,
                        input logic [DW-1:0] lv, input logic [3:0] ra,
                        input logic [3:0] rb, input string req);
        logic [DW-1:0] mg [15];
        int os;
        int ns;
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_data = wd;
        chg_en = ce; chg_mode = cm; chg_link_en = le; chg_link_val = lv;
        cur_mode = m_mode; rd_a_idx = ra; rd_b_idx = rb;
        #1;
        check(req, rd_a_data, tb_read(ra));
        check(req, rd_b_data, tb_read(rb));
        for (int i = 0; i < 15; i++) mg[i] = m_live[i];
        if (we && wi != 4'd15) mg[wi] = wd;   // R10: write lands before the swap
        if (ce) begin
            os = tb_slot(m_mode);
            ns = tb_slot(cm);
            m_b13[os] = mg[13];
            m_b14[os] = mg[14];
            if (le) m_b14[ns] = lv;
            mg[13] = m_b13[ns];
            mg[14] = m_b14[ns];
            if (cm == M_FIQ && m_mode != M_FIQ) begin
                for (int i = 0; i < 5; i++) begin m_usr[i] = mg[8+i]; mg[8+i] = m_fiq[i]; end
            end else if (m_mode == M_FIQ && cm != M_FIQ) begin
                for (int i = 0; i < 5; i++) begin m_fiq[i] = mg[8+i]; mg[8+i] = m_usr[i]; end
            end
            m_mode = cm;
        end
        for (int i = 0; i < 15; i++) m_live[i] = mg[i];
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 8; i++)
            step(1'b0, 4'd0, '0, 1'b0, m_mode, 1'b0, '0, 4'(2*i), 4'(2*i+1), req);
    endtask

    task automatic change(input logic [4:0] cm, input logic le, input logic [DW-1:0] lv,
                          input string req);
        step(1'b0, 4'd0, '0, 1'b1, cm, le, lv, 4'd13, 4'd14, req);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            bad_cnt++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: everything reads zero after reset; R2: index 15 reads zero
        read_all("R1");
        // R3: same-cycle read sees the old value, next cycle sees the new one
        for (int i = 0; i < 15; i++)
            step(1'b1, 4'(i), 32'h1000_0000 + DW'(i), 1'b0, m_mode, 1'b0, '0, 4'(i), 4'(i), "R3");
        read_all("R3");
        // R2: a write to index 15 is dropped
        step(1'b1, 4'd15, 32'hDEAD_BEEF, 1'b0, m_mode, 1'b0, '0, 4'd15, 4'd0, "R2");
        read_all("R2");
        // R6 and R7: enter fast interrupt with a return address
        change(M_FIQ, 1'b1, 32'hA5A5_0001, "R6");
        read_all("R7");
        // R10: write r8 in fast mode, then write r9 in the cycle that leaves it
        step(1'b1, 4'd8, 32'hF1F1_0008, 1'b0, m_mode, 1'b0, '0, 4'd8, 4'd9, "R10");
        step(1'b1, 4'd9, 32'hF1F1_0009, 1'b1, M_IRQ, 1'b0, '0, 4'd8, 4'd9, "R10");
        read_all("R8");
        change(M_FIQ, 1'b0, '0, "R10");
        read_all("R10");
        // R5: change to the same mode keeps r13/r14
        change(M_FIQ, 1'b0, '0, "R5");
        read_all("R5");
        // R4: user and system share the stack/link slot
        change(M_USR, 1'b0, '0, "R8");
        step(1'b1, 4'd13, 32'h5555_0013, 1'b0, m_mode, 1'b0, '0, 4'd13, 4'd14, "R4");
        change(M_SYS, 1'b0, '0, "R4");
        read_all("R4");
        // R9: changes between normal modes leave r0-r12 alone
        change(M_IRQ, 1'b1, 32'h0BAD_0014, "R9");
        change(M_SVC, 1'b0, '0, "R9");
        read_all("R9");
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic          we = ($urandom % 2) == 0;
            logic [3:0]    wi = 4'($urandom % 16);
            logic          ce = ($urandom % 6) == 0;
            logic [4:0]    cm = legal_modes[$urandom % 7];
            logic          le = ($urandom % 2) == 0;
            step(we, wi, DW'($urandom), ce, cm, le, DW'($urandom),
                 4'($urandom % 16), 4'($urandom % 16), "R3");
        end
        read_all("R5");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

endmodule